// File: doc/BRIEF.md
# Wavefront Collision Map Grid

This block is a synchronous grid of cells in three layers that finds where expanding fronts meet. Software-side logic first marks a few sites as seeds, one per write, and then pulses `start`. From that edge the top layer behaves as an excitable medium. Each seed is set at once. On every later cycle, any unset cell that has a set orthogonal neighbour becomes set and remains set. The result is a diamond-shaped front around each seed that grows by one cell per cycle.

The middle layer holds a threshold cell at every site. Each one counts how many of the eight surrounding top-layer cells are set, and it fires at five or more. On a normal front at most four neighbours are set, so only sites where fronts crowd together fire. The bottom layer is the memory that is read out. A bottom cell makes its decision once, at the edge where its top cell first becomes set. It latches high if the threshold cell for that same top-layer snapshot is quiet, and it stays low otherwise. The low cells that a front has swept over therefore trace the boundaries between the seeds' regions.

The run ends when a cycle adds no new top-layer cell. At that point `done` rises and `steps` holds the number of cycles that grew the front.

Top module: `wcd_grid`

## Requirements
- R1: After reset, `map_o`, `busy`, `done` and `steps` are all zero.
- R2: A pulse on `seed_we` marks the site (`seed_row`, `seed_col`) as a seed. Bit index `row*COLS+col` is used for both the seed mask and `map_o`. A start accepted at an edge sets every seed's map bit to 1 at that same edge and raises `busy`.
- R3: While busy, on each step an unset top cell becomes set if any of its up, down, left or right neighbours was set before the step. Sites outside the grid count as unset. A single seed in a corner therefore fills the whole grid with ones on the map, and `steps` reaches ROWS+COLS-2.
- R4: A site's threshold is met when 5 or more of its 8 surrounding top cells are set, with out-of-grid sites counted as unset. A cell reached while its threshold is met stays 0 on the map. For example, seeds at (2,2) and (2,4) leave map bits (1,3) and (3,3) at 0.
- R5: A map bit is decided only at the edge where its top cell first becomes set. It becomes 1 if the threshold for the pre-step top state is unmet, and it never changes again until the next start. For the seeds in R4, bit (2,3) is 1.
- R6: At the first busy edge that adds no new top cell, `busy` falls and `done` rises. `steps` counts the busy edges that added cells, and `busy` and `done` are never both high.
- R7: `start` has no effect while `busy` is high. An accepted start empties the seed mask, so a later start without new seed writes produces an empty run.
- R8: An accepted start clears the previous map, so that only the new seeds read 1 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_we | input | 1 | Write one seed site |
| seed_row | input | RW | Seed row |
| seed_col | input | CW | Seed column |
| start | input | 1 | Begin a run from the stored seeds |
| busy | output | 1 | Fronts still growing |
| done | output | 1 | Run finished, map final |
| steps | output | SW | Growth steps of the last run |
| map_o | output | ROWS*COLS | Bottom-layer map, bit row*COLS+col |

## Verification
The assertions assume that `start` is only acted on from the idle state, and that the top and bottom layers only move forward during a run. The monotonic checks are therefore gated by `busy` and re-armed by the start edge. The stimulus writes seeds only while the block is idle, except for one deliberate start pulse during a run, and it waits for `done` before it reads the map. Seed sites are always inside the grid. The bench's reference model steps the grid behaviourally from its own arrays and compares the map and status every cycle.

// File: rtl/wcd_pkg.sv
package wcd_pkg;
   // flat bit position of a grid site
   function automatic int site_index(input int row, input int col, input int cols);
      return row * cols + col;
   endfunction
endpackage

// File: rtl/wcd_prop.sv
module wcd_prop #(
   parameter int ROWS = 8,
   parameter int COLS = 8,
   localparam int N = ROWS * COLS
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic         run_i,
   input  logic [N-1:0] seeds_i,
   output logic [N-1:0] top_o,
   output logic [N-1:0] fresh_o,
   output logic         quiet_o
);
   import wcd_pkg::*;

   logic [N-1:0] top_q;

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         logic up, dn, lf, rt;
         if (r > 0) begin : g_up
            assign up = top_q[site_index(r-1, c, COLS)];
         end else begin : g_no_up
            assign up = 1'b0;
         end
         if (r < ROWS-1) begin : g_dn
            assign dn = top_q[site_index(r+1, c, COLS)];
         end else begin : g_no_dn
            assign dn = 1'b0;
         end
         if (c > 0) begin : g_lf
            assign lf = top_q[site_index(r, c-1, COLS)];
         end else begin : g_no_lf
            assign lf = 1'b0;
         end
         if (c < COLS-1) begin : g_rt
            assign rt = top_q[site_index(r, c+1, COLS)];
         end else begin : g_no_rt
            assign rt = 1'b0;
         end
         assign fresh_o[site_index(r, c, COLS)] =
            ~top_q[site_index(r, c, COLS)] & (up | dn | lf | rt);
      end
   end

   assign quiet_o = (fresh_o == '0);
   assign top_o   = top_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       top_q <= '0;
      else if (load_i)  top_q <= seeds_i;
      else if (run_i)   top_q <= top_q | fresh_o;
   end

   AST_TOP_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !load_i) |=> (($past(top_q) & ~top_q) == '0)); // R3
endmodule

// File: rtl/wcd_thresh.sv
module wcd_thresh #(
   parameter int ROWS   = 8,
   parameter int COLS   = 8,
   parameter int THRESH = 5,
   localparam int N  = ROWS * COLS,
   localparam int NW = $clog2(N)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         run_i,
   input  logic [N-1:0] top_i,
   output logic [N-1:0] hit_o,
   output logic [N-1:0] mid_o
);
   logic [N-1:0] mid_q;

   always_comb begin
      hit_o = '0;
      for (int r = 0; r < ROWS; r++) begin
         for (int c = 0; c < COLS; c++) begin
            int cnt;
            int k;
            cnt = 0;
            for (int dr = -1; dr <= 1; dr++) begin
               for (int dc = -1; dc <= 1; dc++) begin
                  k = (r + dr) * COLS + (c + dc);
                  if (!(dr == 0 && dc == 0) && (r + dr) >= 0 && (r + dr) < ROWS &&
                      (c + dc) >= 0 && (c + dc) < COLS)
                     cnt = cnt + int'(top_i[k[NW-1:0]]);
               end
            end
            k = r * COLS + c;
            hit_o[k[NW-1:0]] = (cnt >= THRESH);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      mid_q <= '0;
      else if (clr_i)  mid_q <= '0;
      else if (run_i)  mid_q <= hit_o;
   end

   assign mid_o = mid_q;

   AST_MID_STAYS_FIRED: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !clr_i) |=> (($past(mid_q) & ~mid_q) == '0)); // R4
endmodule

// File: rtl/wcd_mem.sv
module wcd_mem #(
   parameter int ROWS = 8,
   parameter int COLS = 8,
   localparam int N = ROWS * COLS
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic         run_i,
   input  logic [N-1:0] seeds_i,
   input  logic [N-1:0] fresh_i,
   input  logic [N-1:0] hit_i,
   output logic [N-1:0] map_o
);
   logic [N-1:0] bot_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       bot_q <= '0;
      else if (load_i)  bot_q <= seeds_i;
      else if (run_i)   bot_q <= bot_q | (fresh_i & ~hit_i);
   end

   assign map_o = bot_q;

   AST_MAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !load_i) |=> (($past(bot_q) & ~bot_q) == '0)); // R5
endmodule

// File: rtl/wcd_grid.sv
module wcd_grid #(
   parameter int ROWS   = 8,
   parameter int COLS   = 8,
   parameter int THRESH = 5,
   localparam int N  = ROWS * COLS,
   localparam int NW = $clog2(N),
   localparam int RW = $clog2(ROWS),
   localparam int CW = $clog2(COLS),
   localparam int SW = $clog2(ROWS + COLS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          seed_we,
   input  logic [RW-1:0] seed_row,
   input  logic [CW-1:0] seed_col,
   input  logic          start,
   output logic          busy,
   output logic          done,
   output logic [SW-1:0] steps,
   output logic [N-1:0]  map_o
);
   if (ROWS < 3 || COLS < 3) begin : g_bad_size
      $error("wcd_grid needs at least 3 rows and 3 columns");
   end
   if (THRESH < 1 || THRESH > 8) begin : g_bad_thresh
      $error("wcd_grid threshold must lie in 1..8");
   end

   logic [N-1:0]  seeds_q;
   logic [N-1:0]  top_w, fresh_w, hit_w, mid_w;
   logic          quiet_w;
   logic          busy_q, done_q;
   logic [SW-1:0] steps_q;
   logic          load_w;
   int            wr_idx;

   assign load_w = start && !busy_q;
   assign wr_idx = int'(seed_row) * COLS + int'(seed_col);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seeds_q <= '0;
      end else begin
         if (load_w) seeds_q <= '0;
         if (seed_we && int'(seed_row) < ROWS && int'(seed_col) < COLS)
            seeds_q[wr_idx[NW-1:0]] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         steps_q <= '0;
      end else if (load_w) begin
         busy_q  <= 1'b1;
         done_q  <= 1'b0;
         steps_q <= '0;
      end else if (busy_q) begin
         if (quiet_w) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end else begin
            steps_q <= steps_q + SW'(1);
         end
      end
   end

   wcd_prop #(.ROWS(ROWS), .COLS(COLS)) u_prop (
      .clk(clk), .rst_n(rst_n), .load_i(load_w), .run_i(busy_q),
      .seeds_i(seeds_q), .top_o(top_w), .fresh_o(fresh_w), .quiet_o(quiet_w));

   wcd_thresh #(.ROWS(ROWS), .COLS(COLS), .THRESH(THRESH)) u_thresh (
      .clk(clk), .rst_n(rst_n), .clr_i(load_w), .run_i(busy_q),
      .top_i(top_w), .hit_o(hit_w), .mid_o(mid_w));

   wcd_mem #(.ROWS(ROWS), .COLS(COLS)) u_mem (
      .clk(clk), .rst_n(rst_n), .load_i(load_w), .run_i(busy_q),
      .seeds_i(seeds_q), .fresh_i(fresh_w), .hit_i(hit_w), .map_o(map_o));

   assign busy  = busy_q;
   assign done  = done_q;
   assign steps = steps_q;

   AST_NOT_BUSY_AND_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_q && done_q)); // R6
   AST_DONE_FREEZES_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> $stable(steps_q)); // R6
   AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy_q) |=> busy_q); // R7
   AST_NEW_MAP_QUIET_MID: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy_q) && busy_q |-> ((map_o & ~$past(map_o) & mid_w) == '0)); // R4
endmodule

// File: tb/wcd_grid_tb.sv
module wcd_grid_tb_top;
   localparam int ROWS = 8;
   localparam int COLS = 8;
   localparam int N    = ROWS * COLS;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          seed_we = 1'b0;
   logic [2:0]    seed_row = '0;
   logic [2:0]    seed_col = '0;
   logic          start = 1'b0;
   logic          busy, done;
   logic [3:0]    steps;
   logic [N-1:0]  map_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // reference model state
   int m_top[N];
   int m_bot[N];
   int m_seed[N];
   int m_new[N];
   int m_hit[N];
   int m_busy = 0, m_done = 0, m_steps = 0;

   always #10 clk = ~clk;

   wcd_grid #(.ROWS(ROWS), .COLS(COLS), .THRESH(5)) dut_i (
      .clk(clk), .rst_n(rst_n), .seed_we(seed_we), .seed_row(seed_row),
      .seed_col(seed_col), .start(start), .busy(busy), .done(done),
      .steps(steps), .map_o(map_o));

   function automatic int set_at(int r, int c);
      if (r < 0 || r >= ROWS || c < 0 || c >= COLS) return 0;
      return m_top[r*COLS+c];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            m_top[i] = 0; m_bot[i] = 0; m_seed[i] = 0;
         end
         m_busy = 0; m_done = 0; m_steps = 0;
      end else begin
         if (m_busy != 0) begin
            int any;
            any = 0;
            for (int r = 0; r < ROWS; r++) begin
               for (int c = 0; c < COLS; c++) begin
                  int cnt;
                  cnt = 0;
                  for (int dr = -1; dr <= 1; dr++)
                     for (int dc = -1; dc <= 1; dc++)
                        if (dr != 0 || dc != 0) cnt += set_at(r+dr, c+dc);
                  m_hit[r*COLS+c] = (cnt >= 5) ? 1 : 0;
                  m_new[r*COLS+c] = (m_top[r*COLS+c] == 0 &&
                     (set_at(r-1,c) + set_at(r+1,c) + set_at(r,c-1) + set_at(r,c+1)) > 0) ? 1 : 0;
                  any += m_new[r*COLS+c];
               end
            end
            if (any == 0) begin
               m_busy = 0; m_done = 1;
            end else begin
               for (int i = 0; i < N; i++) begin
                  if (m_new[i] != 0) begin
                     m_top[i] = 1;
                     m_bot[i] = (m_hit[i] == 0) ? 1 : 0;
                  end
               end
               m_steps++;
            end
         end else if (start) begin
            for (int i = 0; i < N; i++) begin
               m_top[i] = m_seed[i]; m_bot[i] = m_seed[i]; m_seed[i] = 0;
            end
            m_busy = 1; m_done = 0; m_steps = 0;
         end
         if (seed_we) m_seed[int'(seed_row)*COLS + int'(seed_col)] = 1;
      end
   end

   function automatic logic [N-1:0] model_map();
      logic [N-1:0] v;
      for (int i = 0; i < N; i++) v[i] = (m_bot[i] != 0);
      return v;
   endfunction

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (map_o !== model_map()) begin
            errors++;
            $display("FAIL R5 map actual %h expected %h", map_o, model_map());
         end
         checks++;
         if (busy !== (m_busy != 0) || done !== (m_done != 0) || int'(steps) != m_steps) begin
            errors++;
            $display("FAIL R6 busy/done/steps actual %0b/%0b/%0d expected %0d/%0d/%0d",
                     busy, done, steps, m_busy, m_done, m_steps);
         end
      end
   end

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic put_seed(int r, int c);
      @(negedge clk);
      seed_we = 1'b1; seed_row = 3'(r); seed_col = 3'(c);
      @(negedge clk);
      seed_we = 1'b0;
   endtask

   task automatic kick();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 200 && done !== 1'b1; i++) @(negedge clk);
   endtask

   initial begin : watchdog
      while (cycles < 20000) begin
         @(posedge clk);
         cycles++;
      end
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 map", 64'(map_o), 64'd0);
      check("R1 status", {61'd0, busy, done, 1'b0}, 64'd0);
      check("R1 steps", 64'(steps), 64'd0);

      // single corner seed
      put_seed(0, 0);
      kick();
      check("R2 seed bit", 64'(map_o[0]), 64'd1);
      check("R2 busy", 64'(busy), 64'd1);
      repeat (3) @(negedge clk);
      kick(); // R7 start during run is ignored
      check("R7 steps continue", 64'(steps), 64'd5);
      wait_done();
      check("R3 full fill", 64'(map_o), {64{1'b1}});
      check("R3 steps", 64'(steps), 64'd14);
      check("R6 done", 64'(done), 64'd1);

      // R7 seed mask emptied, R8 map cleared
      kick();
      check("R8 map cleared", 64'(map_o), 64'd0);
      wait_done();
      check("R7 empty run steps", 64'(steps), 64'd0);
      check("R7 empty run map", 64'(map_o), 64'd0);

      // two seeds: collision sites
      put_seed(2, 2);
      put_seed(2, 4);
      kick();
      check("R8 only new seeds", 64'(map_o), (64'd1 << 18) | (64'd1 << 20));
      wait_done();
      check("R4 site 1,3 low", 64'(map_o[11]), 64'd0);
      check("R4 site 3,3 low", 64'(map_o[27]), 64'd0);
      check("R5 site 2,3 high", 64'(map_o[19]), 64'd1);
      check("R5 whole map", 64'(map_o), 64'(model_map()));

      // scattered seeds
      put_seed(0, 7);
      put_seed(7, 0);
      put_seed(4, 4);
      put_seed(6, 6);
      put_seed(1, 2);
      kick();
      wait_done();
      check("R3 scattered map", 64'(map_o), 64'(model_map()));
      check("R6 scattered steps", 64'(steps), 64'(m_steps));
      repeat (2) @(negedge clk);
      check("R6 done holds", 64'(done), 64'd1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule